// File: doc/BRIEF.md
# Vector Element Sequencer with Restart-Point Control

This block runs the element loop of one vector instruction at a time. An issue request carries the instruction class (reduction or ordinary elementwise), the restart point held in the vector start register, and the active vector length. The block then presents one element index per cycle to an external datapath. Each cycle it samples a per-element fault input and an interrupt request. From these it decides whether the instruction retires or traps. In the same cycle as that decision it writes back the new restart point.

Trap handling takes one of three paths. A reduction issued with a nonzero restart point is rejected precisely, and the restart point is left as it was. An ordinary instruction that faults or is interrupted mid-loop records the element where it must resume. A reduction cannot resume, so it either reports a restart point of zero or, under the default policy, holds an interrupt until it retires and takes it straight after. A parameter selects between these two reduction policies.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `iss_ready` is 1 and `elem_valid`, `retire`, `trap` and `vs_we` are 0.
- R2: A reduction (`iss_is_red`=1) issued with `iss_vstart` nonzero issues no element. One cycle after issue it pulses `trap` with `trap_cause`=2'b01 (illegal instruction), and `vs_wdata` equals the issued `iss_vstart`, so the restart point is unchanged.
- R3: An accepted instruction with `iss_vstart` < `iss_vl` drives `elem_valid` with indices `iss_vstart` to `iss_vl`-1, one per consecutive cycle from the cycle after issue. In the cycle after the last index it pulses `retire` with `vs_wdata`=0.
- R4: An instruction that is not rejected and has `iss_vstart` >= `iss_vl` issues no element and pulses `retire` one cycle after issue, with `vs_wdata`=0.
- R5: On an ordinary instruction, `elem_fault` high during an element cycle causes a `trap` with `trap_cause`=2'b10 in the next cycle. `vs_wdata` is that element's index, and no later element is issued.
- R6: On an ordinary instruction, `irq` high during an element cycle causes a `trap` with `trap_cause`=2'b11 in the next cycle. `vs_wdata` is the index presented in that cycle, which counts as not executed.
- R7: When `elem_fault` and `irq` are both high in the same element cycle, the fault wins: the cause is 2'b10.
- R8: A fault during a reduction traps with `trap_cause`=2'b10 and `vs_wdata`=0.
- R9: With `RED_IRQ_DEFER`=1 (default), an interrupt during a reduction does not stop the loop. The reduction retires normally, and in the very next cycle the block pulses `trap` with `trap_cause`=2'b11 and `vs_wdata`=0.
- R10: With `RED_IRQ_DEFER`=0, an interrupt during a reduction traps in the next cycle with `trap_cause`=2'b11 and `vs_wdata`=0, and the reduction does not retire.
- R11: `vs_we` is high exactly in the cycles where `trap` or `retire` is high, and `trap` and `retire` are never high together.
- R12: `iss_ready` is 0 from the cycle after an accepted issue up to and including the final pulse. Requests made in that window are ignored. It is 1 again in the cycle after the final pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Block idle and able to accept an issue |
| iss_is_red | input | 1 | 1 = reduction class, 0 = ordinary elementwise |
| iss_vstart | input | IDX_W | Current restart point |
| iss_vl | input | IDX_W | Active vector length |
| elem_valid | output | 1 | An element index is presented this cycle |
| elem_idx | output | IDX_W | Element index for the datapath |
| elem_fault | input | 1 | Synchronous fault on the presented element |
| irq | input | 1 | Interrupt request, sampled at element boundaries |
| retire | output | 1 | Instruction retired (one-cycle pulse) |
| trap | output | 1 | Trap taken (one-cycle pulse) |
| trap_cause | output | 2 | 01 illegal, 10 element fault, 11 interrupt |
| vs_we | output | 1 | Write enable for the restart point |
| vs_wdata | output | IDX_W | New restart point value |

## Verification
Two pairs of events can land in the same cycle. The first is a fault and an interrupt on one element. The bench raises both inputs while a chosen index is presented and expects cause 10 with that index as the restart point. The second is a deferred interrupt that arrives on the last element of a reduction, so the interrupt meets the retire decision. The bench raises `irq` on that last index and expects the retire pulse first, then the interrupt trap in the next cycle with a zero restart point. The same stimulus on an instance built with the abort policy must give an immediate interrupt trap and no retire.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the vector element sequencer.
// Assumes: trap cause codes are decoded outside by the trap logic.
package vseq_pkg;
    typedef enum logic [1:0] {
        TC_NONE    = 2'b00,
        TC_ILLEGAL = 2'b01,
        TC_FAULT   = 2'b10,
        TC_IRQ     = 2'b11
    } trap_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_DONE  = 2'b10,
        ST_DEFER = 2'b11
    } seq_state_e;
endpackage

// File: rtl/vseq_issue_chk.sv
`timescale 1ns/1ps
// Module: vseq_issue_chk
// Classifies an issue request: precise rejection of a reduction with a
// nonzero restart point, or an empty loop (restart point at or past vl).
// Assumes: purely combinational, inputs stable while iss_valid is high.
module vseq_issue_chk #(
    parameter int IDX_W = 8
) (
    input  logic             is_red,
    input  logic [IDX_W-1:0] vstart,
    input  logic [IDX_W-1:0] vl,
    output logic             reject,
    output logic             empty
);
    // Decide rejection and empty-loop status from the request fields.
    always_comb begin
        reject = is_red && (vstart != '0);
        empty  = !reject && (vstart >= vl);
    end
endmodule

// File: rtl/vseq_elem_ctr.sv
`timescale 1ns/1ps
// Module: vseq_elem_ctr
// Holds the current element index and the loop bound for one instruction.
// Assumes: load and step are never high together; step only while running.
module vseq_elem_ctr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [IDX_W-1:0] load_vl,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             is_last
);
    localparam int EXT_W = IDX_W + 1;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] vl_q;
    logic [EXT_W-1:0] idx_plus1;

    // Load the start point and bound at issue, advance once per element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            vl_q  <= '0;
        end else if (load) begin
            idx_q <= load_idx;
            vl_q  <= load_vl;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Flag the final element of the loop.
    always_comb begin
        idx_plus1 = {1'b0, idx_q} + EXT_W'(1);
        is_last   = (idx_plus1 == {1'b0, vl_q});
        idx       = idx_q;
    end
endmodule

// File: rtl/vseq_trap_arb.sv
`timescale 1ns/1ps
// Module: vseq_trap_arb
// Per element cycle, decides between trap, retire and step.
// A fault beats an interrupt. A reduction reports restart point zero.
// RED_IRQ_DEFER picks whether a reduction interrupt is held until retire
// or aborts the loop.
// Assumes: inputs are only meaningful while active is high.
module vseq_trap_arb
    import vseq_pkg::*;
#(
    parameter int IDX_W         = 8,
    parameter bit RED_IRQ_DEFER = 1'b1
) (
    input  logic             active,
    input  logic             is_red,
    input  logic [IDX_W-1:0] idx,
    input  logic             is_last,
    input  logic             fault,
    input  logic             irq,
    output logic             do_trap,
    output trap_cause_e      cause,
    output logic [IDX_W-1:0] trap_vs,
    output logic             do_retire,
    output logic             do_step,
    output logic             set_pend
);
    logic irq_aborts;
    logic irq_holds;

    // Pick how an interrupt acts on the current instruction class.
    generate
        if (RED_IRQ_DEFER) begin : g_defer
            always_comb begin
                irq_aborts = irq && !is_red;
                irq_holds  = irq && is_red;
            end
        end else begin : g_abort
            always_comb begin
                irq_aborts = irq;
                irq_holds  = 1'b0;
            end
        end
    endgenerate

    // Prioritise fault over interrupt over normal progress.
    always_comb begin
        do_trap   = 1'b0;
        do_retire = 1'b0;
        do_step   = 1'b0;
        set_pend  = 1'b0;
        cause     = TC_NONE;
        trap_vs   = is_red ? '0 : idx;
        if (active) begin
            if (fault) begin
                do_trap = 1'b1;
                cause   = TC_FAULT;
            end else if (irq_aborts) begin
                do_trap = 1'b1;
                cause   = TC_IRQ;
            end else begin
                set_pend  = irq_holds;
                do_retire = is_last;
                do_step   = !is_last;
            end
        end
    end
endmodule

// File: rtl/vec_elem_seq.sv
`timescale 1ns/1ps
// Module: vec_elem_seq (top)
// Runs the element loop of one vector instruction and produces the
// retire/trap pulses and the restart point write. All pulse outputs are
// registered. The block is back in idle the cycle after its final pulse.
// Assumes: one instruction in flight; elem_fault refers to the index
// presented in the same cycle.
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int IDX_W         = 8,
    parameter bit RED_IRQ_DEFER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    output logic             iss_ready,
    input  logic             iss_is_red,
    input  logic [IDX_W-1:0] iss_vstart,
    input  logic [IDX_W-1:0] iss_vl,
    output logic             elem_valid,
    output logic [IDX_W-1:0] elem_idx,
    input  logic             elem_fault,
    input  logic             irq,
    output logic             retire,
    output logic             trap,
    output logic [1:0]       trap_cause,
    output logic             vs_we,
    output logic [IDX_W-1:0] vs_wdata
);
    seq_state_e       state_q, state_d;
    logic             red_q;
    logic             pend_q, pend_d;
    logic             accept;
    logic             reject, empty;
    logic [IDX_W-1:0] cur_idx;
    logic             is_last;
    logic             a_trap, a_retire, a_step, a_pend;
    trap_cause_e      a_cause;
    logic [IDX_W-1:0] a_vs;
    logic             retire_d, trap_d;
    trap_cause_e      cause_d;
    logic [IDX_W-1:0] wdata_d;
    trap_cause_e      cause_q;
    logic             retire_q, trap_q;
    logic [IDX_W-1:0] wdata_q;

    assign iss_ready  = (state_q == ST_IDLE);
    assign accept     = iss_ready && iss_valid;
    assign elem_valid = (state_q == ST_RUN);
    assign elem_idx   = cur_idx;

    vseq_issue_chk #(.IDX_W(IDX_W)) u_chk (
        .is_red (iss_is_red),
        .vstart (iss_vstart),
        .vl     (iss_vl),
        .reject (reject),
        .empty  (empty)
    );

    vseq_elem_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_idx (iss_vstart),
        .load_vl  (iss_vl),
        .step     (a_step),
        .idx      (cur_idx),
        .is_last  (is_last)
    );

    vseq_trap_arb #(.IDX_W(IDX_W), .RED_IRQ_DEFER(RED_IRQ_DEFER)) u_arb (
        .active    (elem_valid),
        .is_red    (red_q),
        .idx       (cur_idx),
        .is_last   (is_last),
        .fault     (elem_fault),
        .irq       (irq),
        .do_trap   (a_trap),
        .cause     (a_cause),
        .trap_vs   (a_vs),
        .do_retire (a_retire),
        .do_step   (a_step),
        .set_pend  (a_pend)
    );

    // Next state and the pulse to register for the following cycle.
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        retire_d = 1'b0;
        trap_d   = 1'b0;
        cause_d  = TC_NONE;
        wdata_d  = '0;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (accept) begin
                    if (reject) begin
                        trap_d  = 1'b1;
                        cause_d = TC_ILLEGAL;
                        wdata_d = iss_vstart;
                        state_d = ST_DONE;
                    end else if (empty) begin
                        retire_d = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (a_pend) pend_d = 1'b1;
                if (a_trap) begin
                    trap_d  = 1'b1;
                    cause_d = a_cause;
                    wdata_d = a_vs;
                    state_d = ST_DONE;
                end else if (a_retire) begin
                    retire_d = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_DONE: begin
                if (pend_q) begin
                    trap_d  = 1'b1;
                    cause_d = TC_IRQ;
                    state_d = ST_DEFER;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_DEFER: begin
                pend_d  = 1'b0;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured class and held interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            red_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (accept) red_q <= iss_is_red;
        end
    end

    // Registered pulse outputs and restart point value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_q <= 1'b0;
            trap_q   <= 1'b0;
            cause_q  <= TC_NONE;
            wdata_q  <= '0;
        end else begin
            retire_q <= retire_d;
            trap_q   <= trap_d;
            cause_q  <= cause_d;
            wdata_q  <= wdata_d;
        end
    end

    assign retire     = retire_q;
    assign trap       = trap_q;
    assign trap_cause = cause_q;
    assign vs_we      = retire_q || trap_q;
    assign vs_wdata   = wdata_q;
endmodule

// File: rtl/vseq_checker.sv
`timescale 1ns/1ps
// Module: vseq_checker
// Port-level properties of the sequencer, attached by bind.
module vseq_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic             iss_is_red,
    input logic [IDX_W-1:0] iss_vstart,
    input logic [IDX_W-1:0] iss_vl,
    input logic             elem_valid,
    input logic [IDX_W-1:0] elem_idx,
    input logic             elem_fault,
    input logic             retire,
    input logic             trap,
    input logic [1:0]       trap_cause,
    input logic             vs_we,
    input logic [IDX_W-1:0] vs_wdata
);
    logic take_rej;
    logic take_empty;
    assign take_rej   = iss_valid && iss_ready && iss_is_red && (iss_vstart != '0);
    assign take_empty = iss_valid && iss_ready && !(iss_is_red && (iss_vstart != '0))
                        && (iss_vstart >= iss_vl);

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_rej |=> (trap && trap_cause == 2'b01 && !elem_valid
                      && vs_wdata == $past(iss_vstart)));

    assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && $past(elem_valid)) |-> (elem_idx == $past(elem_idx) + 1'b1));

    assert_retire_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (vs_we && vs_wdata == '0));

    assert_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_empty |=> (retire && !elem_valid));

    assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && elem_fault) |=> (trap && trap_cause == 2'b10));

    assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vs_we == (trap || retire));

    assert_excl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && retire));

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> !iss_ready);

    assert_idle_after_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> iss_ready);
endmodule

bind vec_elem_seq vseq_checker #(.IDX_W(IDX_W)) u_vseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_is_red (iss_is_red),
    .iss_vstart (iss_vstart),
    .iss_vl     (iss_vl),
    .elem_valid (elem_valid),
    .elem_idx   (elem_idx),
    .elem_fault (elem_fault),
    .retire     (retire),
    .trap       (trap),
    .trap_cause (trap_cause),
    .vs_we      (vs_we),
    .vs_wdata   (vs_wdata)
);

// File: tb/sim_vec_elem_seq.sv
`timescale 1ns/1ps
// Directed bench: u0 uses the default defer policy, u1 the abort policy.
module sim_vec_elem_seq;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         iss_valid = 1'b0;
    logic         iss_is_red = 1'b0;
    logic [W-1:0] iss_vstart = '0;
    logic [W-1:0] iss_vl = '0;
    logic         elem_fault = 1'b0;
    logic         irq = 1'b0;

    logic         o0_ready, o0_ev, o0_ret, o0_trap, o0_we;
    logic [W-1:0] o0_idx, o0_wd;
    logic [1:0]   o0_cause;
    logic         o1_ready, o1_ev, o1_ret, o1_trap, o1_we;
    logic [W-1:0] o1_idx, o1_wd;
    logic [1:0]   o1_cause;

    logic         sel = 1'b0;
    logic         m_ready, m_ev, m_ret, m_trap, m_we;
    logic [W-1:0] m_idx, m_wd;
    logic [1:0]   m_cause;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    int  r_nelem, r_nret, r_ntrap, r_cause, r_twd, r_rwd, r_tcyc, r_rcyc, r_webad;
    bit  r_idx_ok, r_busyready;

    always #2 clk = ~clk;

    vec_elem_seq #(.IDX_W(W), .RED_IRQ_DEFER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(o0_ready),
        .iss_is_red(iss_is_red), .iss_vstart(iss_vstart), .iss_vl(iss_vl),
        .elem_valid(o0_ev), .elem_idx(o0_idx), .elem_fault(elem_fault), .irq(irq),
        .retire(o0_ret), .trap(o0_trap), .trap_cause(o0_cause),
        .vs_we(o0_we), .vs_wdata(o0_wd)
    );

    vec_elem_seq #(.IDX_W(W), .RED_IRQ_DEFER(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(o1_ready),
        .iss_is_red(iss_is_red), .iss_vstart(iss_vstart), .iss_vl(iss_vl),
        .elem_valid(o1_ev), .elem_idx(o1_idx), .elem_fault(elem_fault), .irq(irq),
        .retire(o1_ret), .trap(o1_trap), .trap_cause(o1_cause),
        .vs_we(o1_we), .vs_wdata(o1_wd)
    );

    always_comb begin
        m_ready = sel ? o1_ready : o0_ready;
        m_ev    = sel ? o1_ev    : o0_ev;
        m_idx   = sel ? o1_idx   : o0_idx;
        m_ret   = sel ? o1_ret   : o0_ret;
        m_trap  = sel ? o1_trap  : o0_trap;
        m_cause = sel ? o1_cause : o0_cause;
        m_we    = sel ? o1_we    : o0_we;
        m_wd    = sel ? o1_wd    : o0_wd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one instruction and record what the selected instance does.
    task automatic run_op(input bit s, input bit red, input int vs, input int vl,
                          input int fault_at, input int irq_at, input bit spam);
        int exp_idx;
        sel = s;
        @(negedge clk);
        iss_valid = 1'b1; iss_is_red = red;
        iss_vstart = W'(vs); iss_vl = W'(vl);
        elem_fault = 1'b0; irq = 1'b0;
        exp_idx = vs;
        r_nelem = 0; r_nret = 0; r_ntrap = 0; r_cause = 0; r_twd = -1; r_rwd = -1;
        r_tcyc = -1; r_rcyc = -1; r_webad = 0; r_idx_ok = 1'b1; r_busyready = 1'b0;
        for (int c = 1; c < 600; c++) begin
            @(negedge clk);
            elem_fault = 1'b0; irq = 1'b0;
            if (spam) begin
                iss_valid = 1'b1; iss_is_red = ~red; iss_vstart = '0; iss_vl = 8'd200;
            end else begin
                iss_valid = 1'b0;
            end
            if (m_ready) begin
                iss_valid = 1'b0;
                break;
            end
            if (m_ev) begin
                r_nelem++;
                if (int'(m_idx) != exp_idx) r_idx_ok = 1'b0;
                exp_idx++;
                if (int'(m_idx) == fault_at) elem_fault = 1'b1;
                if (int'(m_idx) == irq_at) irq = 1'b1;
            end
            if (m_trap) begin
                r_ntrap++; r_cause = int'(m_cause); r_twd = int'(m_wd); r_tcyc = c;
            end
            if (m_ret) begin
                r_nret++; r_rwd = int'(m_wd); r_rcyc = c;
            end
            if ((m_trap || m_ret) != m_we) r_webad++;
        end
        iss_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(o0_ready == 1'b1, "R1", "ready after reset", int'(o0_ready), 1);
        chk(!o0_ev && !o0_ret && !o0_trap && !o0_we, "R1", "quiet outputs after reset",
            int'({o0_ev, o0_ret, o0_trap, o0_we}), 0);
    endtask

    task automatic t_ord_full();
        run_op(1'b0, 1'b0, 0, 5, -1, -1, 1'b0);
        chk(r_nelem == 5 && r_idx_ok, "R3", "elements 0..4", r_nelem, 5);
        chk(r_nret == 1 && r_rcyc == 6 && r_rwd == 0, "R3", "retire cycle", r_rcyc, 6);
        chk(r_ntrap == 0, "R3", "no trap", r_ntrap, 0);
        chk(r_webad == 0, "R11", "we with retire", r_webad, 0);
    endtask

    task automatic t_ord_mid();
        run_op(1'b0, 1'b0, 3, 9, -1, -1, 1'b0);
        chk(r_nelem == 6 && r_idx_ok, "R3", "elements 3..8 from restart point", r_nelem, 6);
        chk(r_nret == 1 && r_rwd == 0, "R3", "restart point cleared", r_rwd, 0);
    endtask

    task automatic t_empty();
        run_op(1'b0, 1'b0, 7, 7, -1, -1, 1'b0);
        chk(r_nelem == 0 && r_nret == 1 && r_rcyc == 1, "R4", "vstart==vl retires at once",
            r_rcyc, 1);
        chk(r_rwd == 0, "R4", "restart point cleared", r_rwd, 0);
        run_op(1'b0, 1'b1, 0, 0, -1, -1, 1'b0);
        chk(r_nelem == 0 && r_nret == 1 && r_ntrap == 0, "R4", "empty reduction retires",
            r_nret, 1);
    endtask

    task automatic t_reject();
        run_op(1'b0, 1'b1, 4, 10, -1, -1, 1'b0);
        chk(r_ntrap == 1 && r_cause == 1 && r_tcyc == 1, "R2", "illegal cause", r_cause, 1);
        chk(r_twd == 4, "R2", "restart point kept", r_twd, 4);
        chk(r_nelem == 0 && r_nret == 0, "R2", "nothing executed", r_nelem, 0);
    endtask

    task automatic t_fault();
        run_op(1'b0, 1'b0, 2, 10, 6, -1, 1'b0);
        chk(r_nelem == 5 && r_idx_ok, "R5", "elements stop at fault", r_nelem, 5);
        chk(r_ntrap == 1 && r_cause == 2 && r_tcyc == 6, "R5", "fault cause", r_cause, 2);
        chk(r_twd == 6, "R5", "resume at faulting index", r_twd, 6);
        chk(r_webad == 0 && r_nret == 0, "R11", "we with trap, no retire", r_webad, 0);
    endtask

    task automatic t_irq();
        run_op(1'b0, 1'b0, 0, 8, -1, 3, 1'b0);
        chk(r_ntrap == 1 && r_cause == 3, "R6", "interrupt cause", r_cause, 3);
        chk(r_twd == 3 && r_nret == 0, "R6", "resume at interrupted index", r_twd, 3);
    endtask

    task automatic t_both();
        run_op(1'b0, 1'b0, 1, 8, 4, 4, 1'b0);
        chk(r_ntrap == 1 && r_cause == 2, "R7", "fault beats interrupt", r_cause, 2);
        chk(r_twd == 4, "R7", "restart point on same element", r_twd, 4);
    endtask

    task automatic t_red_fault();
        run_op(1'b0, 1'b1, 0, 6, 2, -1, 1'b0);
        chk(r_ntrap == 1 && r_cause == 2, "R8", "reduction fault cause", r_cause, 2);
        chk(r_twd == 0 && r_nret == 0, "R8", "reduction restart point zero", r_twd, 0);
    endtask

    task automatic t_red_defer(input int at);
        run_op(1'b0, 1'b1, 0, 6, -1, at, 1'b0);
        chk(r_nelem == 6 && r_nret == 1 && r_rcyc == 7, "R9", "reduction runs to retire",
            r_rcyc, 7);
        chk(r_ntrap == 1 && r_tcyc == 8 && r_cause == 3, "R9", "held interrupt after retire",
            r_tcyc, 8);
        chk(r_twd == 0 && r_webad == 0, "R9", "held interrupt restart point", r_twd, 0);
    endtask

    task automatic t_spam();
        run_op(1'b0, 1'b0, 1, 4, -1, -1, 1'b1);
        chk(r_nelem == 3 && r_idx_ok && r_nret == 1, "R12", "busy requests ignored",
            r_nelem, 3);
        chk(r_busyready == 1'b0, "R12", "not ready while busy", int'(r_busyready), 0);
        @(negedge clk);
        chk(o0_ready == 1'b1 && !o0_ev, "R12", "idle after pulse", int'(o0_ready), 1);
    endtask

    task automatic t_abort();
        run_op(1'b1, 1'b1, 0, 6, -1, 2, 1'b0);
        chk(r_ntrap == 1 && r_cause == 3 && r_tcyc == 4, "R10", "abort interrupt trap",
            r_tcyc, 4);
        chk(r_twd == 0 && r_nret == 0 && r_nelem == 3, "R10", "abort restart point zero",
            r_twd, 0);
        sel = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ord_full();
        t_ord_mid();
        t_empty();
        t_reject();
        t_fault();
        t_irq();
        t_both();
        t_red_fault();
        t_red_defer(2);
        t_red_defer(5);
        t_spam();
        t_abort();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule